// File: doc/BRIEF.md
# Corner-Turn Write Address Mapper

This block sits in front of the write side of a corner-turn store. It takes a stream of complex samples d(x, y) of a square matrix (4096 by 4096 by default), each with its range-line index x and azimuth index y, and returns for every sample the memory coordinates it belongs to: chip group, bank, row and column. It also passes the sample through with its 64 bits split into a 32-bit real part and a 32-bit imaginary part, because those two halves go to two parallel chips of the same group.

The placement follows a two-level interleave. Four range lines form one unit. Along y, blocks of four columns alternate between the two chip groups. Across units, the banks are taken in turn modulo four. A 4-word burst holds the four x values of one y. When the writer interleaves its y order accordingly, each burst goes to the other group from the one before it, and a later column-order read can rotate over the banks. One cycle of latency is added. The block keeps a ping-pong side bit that selects which half of the memory pair the frame is written to. It flips after the frame's final element is accepted, so the next frame lands in the other half.

Top module: `ctm_wr_mapper`

## Requirements
- R1: After the synchronous active-low reset, out_valid, frame_done and out_side are 0, and the side bit is back at half 0 even if it had flipped.
- R2: A sample accepted with in_valid high gives exactly one output with out_valid high on the next clock edge. A cycle with in_valid low gives out_valid low on the next edge.
- R3: out_group is 1 when (y mod 8) >= 4 and 0 otherwise.
- R4: out_bank equals floor(x/4) mod 4.
- R5: With s = floor(x/16), j = 4*floor(y/8) + (y mod 4) and q = 2048*s + j, out_row = floor(q/128) and out_col = 4*(q mod 128) + (x mod 4). With the defaults, row is 12 bits and column is 9 bits.
- R6: out_burst_first is 1 exactly when x mod 4 = 0, which is the first word of a 4-word burst.
- R7: out_re carries in_data[31:0] and out_im carries in_data[63:32] of the same sample.
- R8: frame_done is high for one cycle, together with the output of the element x = y = 4095, and at no other time.
- R9: The output of the final element still carries the old out_side. Every output after it carries the other half until the next final element.
- R10: The final coordinates presented while in_valid is low raise no frame_done and do not flip the side.
- R11: When the writer feeds four x per y and orders y as 0,4,1,5,2,6,3,7 inside each block of eight, out_group changes on every burst and stays constant within a burst.
- R12: Distinct (x, y) pairs never map to the same (group, bank, row, column).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_x | input | DIM_W (12) | Range-line index x |
| in_y | input | DIM_W (12) | Azimuth index y |
| in_data | input | 64 | Sample: imaginary in upper half, real in lower half |
| out_valid | output | 1 | Mapped sample valid |
| out_group | output | 1 | Chip group select |
| out_bank | output | BANK_W (2) | Bank index |
| out_row | output | ROW_W (12) | Row address |
| out_col | output | COL_W (9) | Column address |
| out_burst_first | output | 1 | First word of a 4-word burst |
| out_re | output | 32 | Real part for the real-part chip |
| out_im | output | 32 | Imaginary part for the imaginary-part chip |
| out_side | output | 1 | Ping-pong half this word is written to |
| frame_done | output | 1 | One-cycle pulse with the frame's final word |

## Verification
Two functions can act on the same clock edge: the address output of the frame's last element, and the flip of the ping-pong side that element causes. The bench feeds that element and then the next frame's first element in back-to-back cycles. It requires the first output to show frame_done with the old side and the second output to show the new side. It also presents the final coordinates with in_valid low, and asserts reset after a flip, to check that the side bit moves only on an accepted final element and returns to half 0 on reset.

// File: rtl/ctm_pkg.sv
// Shared constants and types for the corner-turn write mapper.
// Assumes 4-word bursts along x and a group selector taken from y bit 2.
package ctm_pkg;
    localparam int BURST_W    = 2;   // log2 of words per burst
    localparam int GRP_BIT    = 2;   // y bit that selects the chip group
    localparam int PARTS      = 2;   // real and imaginary chips per group
    localparam int PART_W     = 32;  // width of one part

    typedef enum logic {
        GRP_LOW  = 1'b0,
        GRP_HIGH = 1'b1
    } grp_e;
endpackage

// File: rtl/ctm_set_locator.sv
// Finds where a sample sits in the interleave: chip group, bank, set slot
// inside the bank and burst slot inside the set. Purely combinational.
// Assumes DIM_W > BURST_W + BANK_W and DIM_W > 3.
module ctm_set_locator
    import ctm_pkg::*;
#(
    parameter int DIM_W  = 12,
    parameter int BANK_W = 2,
    localparam int SET_W  = DIM_W - BURST_W - BANK_W,
    localparam int SLOT_W = DIM_W - 1
) (
    input  logic [DIM_W-1:0]  x,
    input  logic [DIM_W-1:0]  y,
    output grp_e              grp,
    output logic [BANK_W-1:0] bank,
    output logic [SET_W-1:0]  set_idx,
    output logic [SLOT_W-1:0] y_slot
);
    // Group from y, bank and set from the four-line unit number,
    // burst slot from the y values that belong to this group.
    always_comb begin
        grp     = grp_e'(y[GRP_BIT]);
        bank    = x[BURST_W+BANK_W-1:BURST_W];
        set_idx = x[DIM_W-1:BURST_W+BANK_W];
        y_slot  = {y[DIM_W-1:GRP_BIT+1], y[GRP_BIT-1:0]};
    end
endmodule

// File: rtl/ctm_burst_seq.sv
// Turns the set slot and burst slot into a row/column address inside one bank.
// Bursts of a bank are numbered set-major; ROW_BURST_W bits of that number
// select the burst inside a row, the rest select the row.
module ctm_burst_seq
    import ctm_pkg::*;
#(
    parameter int SET_W       = 8,
    parameter int SLOT_W      = 11,
    parameter int ROW_BURST_W = 7,
    localparam int SEQ_W = SET_W + SLOT_W,
    localparam int ROW_W = SEQ_W - ROW_BURST_W,
    localparam int COL_W = ROW_BURST_W + BURST_W
) (
    input  logic [SET_W-1:0]   set_idx,
    input  logic [SLOT_W-1:0]  y_slot,
    input  logic [BURST_W-1:0] word_in_burst,
    output logic [ROW_W-1:0]   row,
    output logic [COL_W-1:0]   col,
    output logic               burst_first
);
    logic [SEQ_W-1:0] seq;

    // Burst number inside the bank, then split into row and column.
    always_comb begin
        seq         = {set_idx, y_slot};
        row         = seq[SEQ_W-1:ROW_BURST_W];
        col         = {seq[ROW_BURST_W-1:0], word_in_burst};
        burst_first = (word_in_burst == '0);
    end
endmodule

// File: rtl/ctm_pingpong.sv
// Holds the ping-pong side bit. It flips when the final element of a frame
// is accepted. Assumes one sample per cycle at most.
module ctm_pingpong (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic is_last,
    output logic side
);
    // Flip the side after the final element, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            side <= 1'b0;
        else if (accept && is_last)
            side <= ~side;
    end
endmodule

// File: rtl/ctm_wr_mapper.sv
// Top of the corner-turn write mapper. Each accepted sample (x, y, data)
// becomes one registered output word with group, bank, row, column, burst
// start flag, real/imaginary parts and the ping-pong side. Latency is one
// cycle. Assumes the caller supplies coordinates; burst ordering is its job.
module ctm_wr_mapper
    import ctm_pkg::*;
#(
    parameter int DIM_W       = 12,
    parameter int BANK_W      = 2,
    parameter int ROW_BURST_W = 7,
    localparam int SAMPLE_W = PARTS * PART_W,
    localparam int SET_W    = DIM_W - BURST_W - BANK_W,
    localparam int SLOT_W   = DIM_W - 1,
    localparam int ROW_W    = SET_W + SLOT_W - ROW_BURST_W,
    localparam int COL_W    = ROW_BURST_W + BURST_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DIM_W-1:0]    in_x,
    input  logic [DIM_W-1:0]    in_y,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    output logic                out_group,
    output logic [BANK_W-1:0]   out_bank,
    output logic [ROW_W-1:0]    out_row,
    output logic [COL_W-1:0]    out_col,
    output logic                out_burst_first,
    output logic [PART_W-1:0]   out_re,
    output logic [PART_W-1:0]   out_im,
    output logic                out_side,
    output logic                frame_done
);
    grp_e              grp_c;
    logic [BANK_W-1:0] bank_c;
    logic [SET_W-1:0]  set_c;
    logic [SLOT_W-1:0] slot_c;
    logic [ROW_W-1:0]  row_c;
    logic [COL_W-1:0]  col_c;
    logic              first_c;
    logic              side_c;
    logic              last_c;
    logic [PART_W-1:0] part_q [PARTS];

    ctm_set_locator #(.DIM_W(DIM_W), .BANK_W(BANK_W)) u_loc (
        .x(in_x), .y(in_y), .grp(grp_c), .bank(bank_c),
        .set_idx(set_c), .y_slot(slot_c)
    );

    ctm_burst_seq #(.SET_W(SET_W), .SLOT_W(SLOT_W), .ROW_BURST_W(ROW_BURST_W)) u_seq (
        .set_idx(set_c), .y_slot(slot_c), .word_in_burst(in_x[BURST_W-1:0]),
        .row(row_c), .col(col_c), .burst_first(first_c)
    );

    // Final element of the frame: both coordinates at their maximum.
    assign last_c = (&in_x) && (&in_y);

    ctm_pingpong u_pp (
        .clk(clk), .rst_n(rst_n), .accept(in_valid), .is_last(last_c), .side(side_c)
    );

    // Valid and frame pulse registers, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            frame_done <= 1'b0;
            out_side   <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            frame_done <= in_valid && last_c;
            if (in_valid)
                out_side <= side_c;
        end
    end

    // Address register, loaded only with an accepted sample.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_group       <= logic'(grp_c);
            out_bank        <= bank_c;
            out_row         <= row_c;
            out_col         <= col_c;
            out_burst_first <= first_c;
        end
    end

    // One register per data part, each feeding its own chip.
    for (genvar p = 0; p < PARTS; p++) begin : g_part
        always_ff @(posedge clk) begin
            if (in_valid)
                part_q[p] <= in_data[p*PART_W +: PART_W];
        end
    end

    assign out_re = part_q[0];
    assign out_im = part_q[1];
endmodule

// File: rtl/ctm_wr_mapper_chk.sv
// Property checker for ctm_wr_mapper, attached by bind below.
module ctm_wr_mapper_chk #(
    parameter int DIM_W  = 12,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DIM_W-1:0]  in_x,
    input logic [DIM_W-1:0]  in_y,
    input logic              out_valid,
    input logic              out_group,
    input logic [BANK_W-1:0] out_bank,
    input logic [ROW_W-1:0]  out_row,
    input logic [COL_W-1:0]  out_col,
    input logic              out_side,
    input logic              frame_done
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    a_r3_group_from_y: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> out_group == $past(in_y[2]));

    a_r4_bank_from_unit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> out_bank == $past(in_x[BANK_W+1:2]));

    a_r5_word_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> out_col[1:0] == $past(in_x[1:0]));

    a_r8_done_at_corner: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (out_valid && out_group && (&out_bank) && (&out_row) && (&out_col)));

    a_r9_side_flips: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done ##1 out_valid |-> out_side != $past(out_side));

    a_r9_side_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !frame_done) ##1 out_valid |-> out_side == $past(out_side));
endmodule

bind ctm_wr_mapper ctm_wr_mapper_chk #(
    .DIM_W(DIM_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_group(out_group), .out_bank(out_bank),
    .out_row(out_row), .out_col(out_col), .out_side(out_side),
    .frame_done(frame_done)
);

// File: tb/ctm_wr_mapper_test.sv
module ctm_wr_mapper_test;
    localparam int CLK_PERIOD = 10;
    localparam int SM_DIM_W   = 6;
    localparam int SM_RB_W    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Full-size instance
    logic        b_valid = 1'b0;
    logic [11:0] b_x = '0, b_y = '0;
    logic [63:0] b_data = '0;
    logic        b_ov, b_grp, b_first, b_side, b_done;
    logic [1:0]  b_bank;
    logic [11:0] b_row;
    logic [8:0]  b_col;
    logic [31:0] b_re, b_im;

    ctm_wr_mapper uut (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_x(b_x), .in_y(b_y),
        .in_data(b_data), .out_valid(b_ov), .out_group(b_grp), .out_bank(b_bank),
        .out_row(b_row), .out_col(b_col), .out_burst_first(b_first),
        .out_re(b_re), .out_im(b_im), .out_side(b_side), .frame_done(b_done)
    );

    // Reduced instance for whole-frame checks
    logic        s_valid = 1'b0;
    logic [5:0]  s_x = '0, s_y = '0;
    logic [63:0] s_data = '0;
    logic        s_ov, s_grp, s_first, s_side, s_done;
    logic [1:0]  s_bank;
    logic [3:0]  s_row;
    logic [4:0]  s_col;
    logic [31:0] s_re, s_im;

    ctm_wr_mapper #(.DIM_W(SM_DIM_W), .BANK_W(2), .ROW_BURST_W(SM_RB_W)) small_uut (
        .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_x(s_x), .in_y(s_y),
        .in_data(s_data), .out_valid(s_ov), .out_group(s_grp), .out_bank(s_bank),
        .out_row(s_row), .out_col(s_col), .out_burst_first(s_first),
        .out_re(s_re), .out_im(s_im), .out_side(s_side), .frame_done(s_done)
    );

    int errs = 0;
    int checks = 0;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Placement computed by arithmetic from the requirements (R3-R6)
    task automatic model(int dimw, int rbw, int x, int y,
                         output int g, output int bk, output int r, output int c);
        int s, j, q;
        g  = ((y % 8) >= 4) ? 1 : 0;
        bk = (x / 4) % 4;
        s  = x / 16;
        j  = 4 * (y / 8) + (y % 4);
        q  = s * ((1 << dimw) / 2) + j;
        r  = q / (1 << rbw);
        c  = 4 * (q % (1 << rbw)) + (x % 4);
    endtask

    function automatic logic [63:0] pat(int x, int y);
        return {32'(y * 977 + 13), 32'(x * 31 + 7)};
    endfunction

    task automatic big_word(int x, int y);
        @(negedge clk);
        b_valid = 1'b1; b_x = 12'(x); b_y = 12'(y); b_data = pat(x, y);
        @(posedge clk); #1;
    endtask

    task automatic big_idle(int x, int y);
        @(negedge clk);
        b_valid = 1'b0; b_x = 12'(x); b_y = 12'(y);
        @(posedge clk); #1;
    endtask

    task automatic sm_word(int x, int y);
        @(negedge clk);
        s_valid = 1'b1; s_x = 6'(x); s_y = 6'(y); s_data = pat(x, y);
        @(posedge clk); #1;
    endtask

    // Stimulus table: x, y, expected group, expected bank
    localparam int NV = 10;
    localparam int VX[NV] = '{0, 1, 3, 4, 5, 16, 47, 1000, 4094, 2};
    localparam int VY[NV] = '{0, 0, 4, 0, 13, 7, 8, 2047, 3, 4092};
    localparam int VG[NV] = '{0, 0, 1, 0, 1, 1, 0, 1, 0, 1};
    localparam int VB[NV] = '{0, 0, 0, 1, 1, 0, 3, 2, 3, 0};

    logic seen [4096];

    initial begin
        #(CLK_PERIOD * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int g, bk, r, c, prev_g, burst_g, key;
        foreach (seen[i]) seen[i] = 1'b0;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid", b_ov, 0);
        chk("R1 done", b_done, 0);
        chk("R1 side", b_side, 0);
        chk("R1 small side", s_side, 0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk on the full-size instance
        for (int i = 0; i < NV; i++) begin
            big_word(VX[i], VY[i]);
            model(12, 7, VX[i], VY[i], g, bk, r, c);
            chk("R2 valid", b_ov, 1);
            chk("R3 group", b_grp, VG[i]);
            chk("R4 bank", b_bank, VB[i]);
            chk("R3 model group", g, VG[i]);
            chk("R5 row", b_row, r);
            chk("R5 col", b_col, c);
            chk("R6 first", b_first, (VX[i] % 4 == 0) ? 1 : 0);
            chk("R7 re", b_re, pat(VX[i], VY[i])[31:0]);
            chk("R7 im", b_im, pat(VX[i], VY[i])[63:32]);
            chk("R8 no done", b_done, 0);
        end

        // R10: final coordinates without valid
        big_idle(4095, 4095);
        chk("R2 idle valid", b_ov, 0);
        chk("R10 no done", b_done, 0);
        big_word(0, 0);
        chk("R10 side kept", b_side, 0);

        // R8/R9: final element, then next frame back-to-back
        big_word(4095, 4095);
        chk("R8 done", b_done, 1);
        chk("R9 old side", b_side, 0);
        chk("R5 corner row", b_row, 4095);
        chk("R5 corner col", b_col, 511);
        big_word(1, 2);
        chk("R8 done once", b_done, 0);
        chk("R9 new side", b_side, 1);
        big_idle(0, 0);
        chk("R2 valid drops", b_ov, 0);

        // R1: reset after a flip, with a sample held at the input
        @(negedge clk);
        rst_n = 1'b0; b_valid = 1'b1; b_x = 12'd3; b_y = 12'd3;
        @(posedge clk); #1;
        chk("R1 reset valid", b_ov, 0);
        chk("R1 reset side", b_side, 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 side after reset", b_side, 0);
        @(negedge clk) b_valid = 1'b0;

        // R11/R12: full frame of the reduced instance in burst order
        prev_g = -1;
        burst_g = 0;
        for (int k = 0; k < 16; k++) begin
            for (int yb = 0; yb < 8; yb++) begin
                for (int p = 0; p < 8; p++) begin
                    for (int xi = 0; xi < 4; xi++) begin
                        int x, y;
                        y = yb * 8 + (p % 2) * 4 + p / 2;
                        x = 4 * k + xi;
                        sm_word(x, y);
                        model(SM_DIM_W, SM_RB_W, x, y, g, bk, r, c);
                        chk("R5 small row", s_row, r);
                        chk("R5 small col", s_col, c);
                        chk("R4 small bank", s_bank, bk);
                        if (xi == 0) begin
                            if (prev_g >= 0) chk("R11 group flips", s_grp, 1 - prev_g);
                            prev_g = s_grp;
                            burst_g = s_grp;
                        end else begin
                            chk("R11 group within burst", s_grp, burst_g);
                        end
                        key = s_grp * 2048 + s_bank * 512 + s_row * 32 + s_col;
                        chk("R12 unique", seen[key], 0);
                        seen[key] = 1'b1;
                        chk("R8 small done", s_done, (x == 63 && y == 63) ? 1 : 0);
                        chk("R9 small side", s_side, 0);
                    end
                end
            end
        end
        sm_word(0, 0);
        chk("R9 small next frame side", s_side, 1);
        @(negedge clk) s_valid = 1'b0;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule